// File: doc/BRIEF.md
# DSI Command Transmit Sequencer

This block takes one host command for a DSI link and turns it into an ordered series of writes on a simple register-write port. That port feeds a DSI host's transmit packet FIFOs. A command carries a three-byte packet header, an optional payload of bytes, a low-power request and a flag that says a reply is expected. A nonzero payload length makes the command a long packet. For a long packet the payload bytes are packed little-endian into 32-bit words and written first. The escape-control word follows, and the header word goes last.

After the header is written, the sequencer waits for the FIFO-empty event that matches the packet kind. When a reply is expected, it then waits for the receive-done event and signals the response unpacker to start. Every wait is bounded by a cycle counter sized to 250 ms at the configured clock. The command ends with a one-cycle done pulse and a status code.

Top module: `dsi_cmd_seq`

## Requirements
- R1: After reset `cmd_ready` is 1, and `reg_wr_en`, `done` and `rsp_start` are 0. `cmd_ready` is high only while idle. A command held valid during a running command is not taken.
- R2: The writes are one per cycle and start in the cycle after acceptance. For a long packet they are every payload word (address 1), then the escape word (address 0), then the header word (address 2). A short packet writes only the escape word and then the header word.
- R3: Payload byte n goes to word n/4 at bit position 8*(n mod 4). A final group of 1 to 3 bytes produces one extra word whose unused upper bytes are zero. A zero-length payload writes no payload word.
- R4: The escape word has bit 7 equal to the low-power request, bit 16 always 1 and all other bits 0. It is written in the cycle just before the header word.
- R5: The header word carries the data identifier in bits 7:0, with the virtual channel in bits 7:6 and the data type in bits 5:0. The word-count low byte is in bits 15:8 and the high byte in bits 23:16. Bits 31:24 are zero.
- R6: A long packet completes only on the payload-FIFO-empty event. A short packet completes only on the header-FIFO-empty event. The other kind of event is ignored. A successful command reports status 0.
- R7: The timeout is TIMEOUT = CLK_HZ/1000*TIMEOUT_MS cycles. If no completion event arrives, `done` rises TIMEOUT+1 cycles after the header-write cycle with status 1 (busy). An event in cycle d (d ≥ 1) after the header write gives `done` in cycle d+1.
- R8: With a reply expected, the receive-done event is awaited after transmit completion under a fresh timeout. `rsp_start` pulses together with an ok `done`. If the receive wait expires, status is 1 and `rsp_start` stays 0.
- R9: A command is rejected when it has a receive buffer with zero receive length, a nonzero receive length without a buffer, or a payload longer than MAX_PL_BYTES. The rejection gives status 2 with `done` in the cycle after acceptance, and no write is made.
- R10: Events arriving at any point after acceptance are held until used; an event during the payload writes or the header cycle ends the wait in its first cycle. Events while idle are dropped. `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command taken when valid |
| cmd_header | input | 24 | Packet header bytes: identifier, word-count low, word-count high |
| cmd_pl_len | input | LEN_W | Payload length in bytes |
| cmd_pl_bytes | input | MAX_PL_BYTES*8 | Payload bytes, byte n at bits 8n+7:8n |
| cmd_lpm | input | 1 | Send the command in low-power mode |
| cmd_rx_buf | input | 1 | A reply buffer is supplied |
| cmd_rx_len | input | RX_LEN_W | Reply buffer length |
| ev_pl_empty | input | 1 | Payload-FIFO-empty event pulse |
| ev_ph_empty | input | 1 | Header-FIFO-empty event pulse |
| ev_rx_done | input | 1 | Receive-data-done event pulse |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 2 | 0 escape control, 1 payload FIFO, 2 header FIFO |
| reg_wr_data | output | 32 | Register write data |
| done | output | 1 | Command finished, one cycle |
| status | output | 2 | 0 ok, 1 busy timeout, 2 invalid arguments |
| rsp_start | output | 1 | Hand-over pulse to the response unpacker |

## Verification
The bench keeps MAX_PL_BYTES at 16. That allows payloads that fill zero to four words, including exact multiples of four and every trailing-group size, plus a rejected length of 17. It sets CLK_HZ to 40000 and TIMEOUT_MS to 1, which shrinks the timeout to 40 cycles. With that setting both the transmit and the receive expiry can be measured to the exact cycle, next to live, early and wrong-kind completion events.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_OK    = 2'd0,
    SEQ_BUSY  = 2'd1,
    SEQ_INVAL = 2'd2
  } seq_status_e;

  typedef enum logic [1:0] {
    RA_ESC     = 2'd0,
    RA_PAYLOAD = 2'd1,
    RA_HEADER  = 2'd2
  } reg_addr_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PAYLOAD,
    S_ESC,
    S_HEADER,
    S_WAIT_TX,
    S_WAIT_RX,
    S_FIN
  } seq_state_e;

  localparam int ESC_LPM_BIT = 7;
  localparam int ESC_BTA_BIT = 16;

  // escape-control value: low-power bit follows the request, turnaround always on
  function automatic logic [31:0] esc_ctrl_word(input logic lpm);
    logic [31:0] w;
    w = '0;
    w[ESC_LPM_BIT] = lpm;
    w[ESC_BTA_BIT] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] header_word(input logic [23:0] hdr);
    return {8'h00, hdr};
  endfunction

  function automatic int unsigned words_for(input int unsigned nbytes);
    return (nbytes + 3) / 4;
  endfunction

  function automatic logic args_bad(input logic has_buf, input logic len_nonzero);
    return has_buf ^ len_nonzero;
  endfunction

endpackage

// File: rtl/dsi_pl_packer.sv
module dsi_pl_packer #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 5,
  parameter int WIDX_W    = 2
) (
  input  logic [MAX_BYTES*8-1:0] bytes_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [WIDX_W-1:0]      idx_i,
  output logic [31:0]            word_o
);
  localparam int PAD_BYTES = (2 ** WIDX_W) * 4;

  logic [7:0] lane_mem [PAD_BYTES];

  for (genvar b = 0; b < PAD_BYTES; b++) begin : g_pad
    if (b < MAX_BYTES) begin : g_real
      assign lane_mem[b] = bytes_i[b*8 +: 8];
    end else begin : g_zero
      assign lane_mem[b] = 8'h00;
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [WIDX_W+1:0] pos;
    assign pos = {idx_i, 2'(l)};
    assign word_o[l*8 +: 8] = (32'(pos) < 32'(len_i)) ? lane_mem[pos] : 8'h00;
  end

endmodule

// File: rtl/dsi_evt_latch.sv
module dsi_evt_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lat_q <= '0;
    else if (clr) lat_q <= '0;
    else          lat_q <= lat_q | ev_i;
  end

  assign hit_o = clr ? '0 : (lat_q | ev_i);

  // R10: a remembered event stays remembered until the sequencer returns to idle
  p_evt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

endmodule

// File: rtl/dsi_wait_timer.sv
module dsi_wait_timer #(
  parameter int unsigned LIMIT = 4,
  parameter int          CW    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || restart)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end

  assign expire_o = run && !restart && (cnt_q == CW'(LIMIT - 1));

  // R7: the wait counter never runs past its limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(cnt_q) < LIMIT));

  // R7: each wait starts from a fresh count
  p_fresh_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/dsi_cmd_seq.sv
module dsi_cmd_seq
  import dsi_seq_pkg::*;
#(
  parameter int          MAX_PL_BYTES = 16,
  parameter int          RX_LEN_W     = 8,
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned TIMEOUT_MS   = 250,
  localparam int         LEN_W        = $clog2(MAX_PL_BYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [23:0]               cmd_header,
  input  logic [LEN_W-1:0]          cmd_pl_len,
  input  logic [MAX_PL_BYTES*8-1:0] cmd_pl_bytes,
  input  logic                      cmd_lpm,
  input  logic                      cmd_rx_buf,
  input  logic [RX_LEN_W-1:0]       cmd_rx_len,
  input  logic                      ev_pl_empty,
  input  logic                      ev_ph_empty,
  input  logic                      ev_rx_done,
  output logic                      reg_wr_en,
  output logic [1:0]                reg_wr_addr,
  output logic [31:0]               reg_wr_data,
  output logic                      done,
  output logic [1:0]                status,
  output logic                      rsp_start
);
  localparam int          MAX_WORDS  = (MAX_PL_BYTES + 3) / 4;
  localparam int          WIDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int unsigned TMO_CYCLES = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int          TMO_W      = $clog2(TMO_CYCLES + 1);
  localparam int          EV_PL      = 0;
  localparam int          EV_PH      = 1;
  localparam int          EV_RX      = 2;

  seq_state_e                state_q, state_d;
  seq_status_e               st_q;
  logic [23:0]               hdr_q;
  logic [MAX_PL_BYTES*8-1:0] pl_q;
  logic [LEN_W-1:0]          len_q;
  logic                      lpm_q;
  logic                      rsp_q;
  logic [WIDX_W-1:0]         widx_q;

  // named internal events
  logic        accept;
  logic        arg_bad;
  logic        long_in;
  logic        long_pkt;
  logic        last_word;
  logic [31:0] pl_word;
  logic [2:0]  ev_vec;
  logic [2:0]  ev_hit;
  logic        tx_hit;
  logic        rx_hit;
  logic        tmr_run;
  logic        tmr_restart;
  logic        tmo_expire;
  logic        to_busy;

  assign cmd_ready = (state_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign arg_bad   = args_bad(cmd_rx_buf, |cmd_rx_len) ||
                     (32'(cmd_pl_len) > 32'(MAX_PL_BYTES));
  assign long_in   = (cmd_pl_len != '0);
  assign long_pkt  = (len_q != '0);
  assign last_word = (widx_q == WIDX_W'(words_for(32'(len_q)) - 1));

  dsi_pl_packer #(
    .MAX_BYTES (MAX_PL_BYTES),
    .LEN_W     (LEN_W),
    .WIDX_W    (WIDX_W)
  ) u_packer (
    .bytes_i (pl_q),
    .len_i   (len_q),
    .idx_i   (widx_q),
    .word_o  (pl_word)
  );

  assign ev_vec = {ev_rx_done, ev_ph_empty, ev_pl_empty};

  dsi_evt_latch #(.N(3)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == S_IDLE),
    .ev_i  (ev_vec),
    .hit_o (ev_hit)
  );

  assign tx_hit      = long_pkt ? ev_hit[EV_PL] : ev_hit[EV_PH];
  assign rx_hit      = ev_hit[EV_RX];
  assign tmr_run     = (state_q == S_WAIT_TX) || (state_q == S_WAIT_RX);
  assign tmr_restart = (state_q == S_WAIT_TX) && tx_hit;

  dsi_wait_timer #(
    .LIMIT (TMO_CYCLES),
    .CW    (TMO_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (tmr_run),
    .restart  (tmr_restart),
    .expire_o (tmo_expire)
  );

  always_comb begin
    state_d = state_q;
    to_busy = 1'b0;
    unique case (state_q)
      S_IDLE:    if (accept) state_d = arg_bad ? S_FIN : (long_in ? S_PAYLOAD : S_ESC);
      S_PAYLOAD: if (last_word) state_d = S_ESC;
      S_ESC:     state_d = S_HEADER;
      S_HEADER:  state_d = S_WAIT_TX;
      S_WAIT_TX: begin
        if (tx_hit)          state_d = rsp_q ? S_WAIT_RX : S_FIN;
        else if (tmo_expire) begin state_d = S_FIN; to_busy = 1'b1; end
      end
      S_WAIT_RX: begin
        if (rx_hit)          state_d = S_FIN;
        else if (tmo_expire) begin state_d = S_FIN; to_busy = 1'b1; end
      end
      S_FIN:     state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      st_q    <= SEQ_OK;
      hdr_q   <= '0;
      pl_q    <= '0;
      len_q   <= '0;
      lpm_q   <= 1'b0;
      rsp_q   <= 1'b0;
      widx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        hdr_q  <= cmd_header;
        pl_q   <= cmd_pl_bytes;
        len_q  <= cmd_pl_len;
        lpm_q  <= cmd_lpm;
        rsp_q  <= cmd_rx_buf;
        widx_q <= '0;
        st_q   <= arg_bad ? SEQ_INVAL : SEQ_OK;
      end
      if (state_q == S_PAYLOAD) widx_q <= widx_q + WIDX_W'(1);
      if (to_busy) st_q <= SEQ_BUSY;
    end
  end

  always_comb begin
    reg_wr_en   = 1'b0;
    reg_wr_addr = RA_ESC;
    reg_wr_data = '0;
    unique case (state_q)
      S_PAYLOAD: begin reg_wr_en = 1'b1; reg_wr_addr = RA_PAYLOAD; reg_wr_data = pl_word; end
      S_ESC:     begin reg_wr_en = 1'b1; reg_wr_addr = RA_ESC;     reg_wr_data = esc_ctrl_word(lpm_q); end
      S_HEADER:  begin reg_wr_en = 1'b1; reg_wr_addr = RA_HEADER;  reg_wr_data = header_word(hdr_q); end
      default:   ;
    endcase
  end

  assign done      = (state_q == S_FIN);
  assign status    = st_q;
  assign rsp_start = done && (st_q == SEQ_OK) && rsp_q;

  // R4: the escape word carries the turnaround bit and is followed at once by the header
  p_esc_bta_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == RA_ESC) |-> reg_wr_data[ESC_BTA_BIT]);
  p_esc_then_hdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == RA_ESC) |=> (reg_wr_en && reg_wr_addr == RA_HEADER));

  // R2: the header is the last write of a command
  p_hdr_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == RA_HEADER) |=> !reg_wr_en);

  // R9: a rejected command finishes at once without writes
  p_inval_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && arg_bad) |=> (done && status == SEQ_INVAL && !reg_wr_en));

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: no command is taken while one is finishing
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || done) |-> !cmd_ready);

endmodule

// File: tb/dsi_cmd_seq_bench.sv
module dsi_cmd_seq_bench;
  localparam int MAXB  = 16;
  localparam int CLKHZ = 40_000;
  localparam int TMS   = 1;
  localparam int TMO   = (CLKHZ / 1000) * TMS;
  localparam int LENW  = $clog2(MAXB + 1);
  localparam int NONE  = -1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [23:0]       cmd_header = '0;
  logic [LENW-1:0]   cmd_pl_len = '0;
  logic [MAXB*8-1:0] cmd_pl_bytes = '0;
  logic              cmd_lpm = 1'b0;
  logic              cmd_rx_buf = 1'b0;
  logic [7:0]        cmd_rx_len = '0;
  logic              ev_pl = 1'b0, ev_ph = 1'b0, ev_rx = 1'b0;
  logic              wr_en;
  logic [1:0]        wr_addr;
  logic [31:0]       wr_data;
  logic              done;
  logic [1:0]        status;
  logic              rsp_start;

  dsi_cmd_seq #(.MAX_PL_BYTES(MAXB), .CLK_HZ(CLKHZ), .TIMEOUT_MS(TMS)) u_dsi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_header(cmd_header), .cmd_pl_len(cmd_pl_len), .cmd_pl_bytes(cmd_pl_bytes),
    .cmd_lpm(cmd_lpm), .cmd_rx_buf(cmd_rx_buf), .cmd_rx_len(cmd_rx_len),
    .ev_pl_empty(ev_pl), .ev_ph_empty(ev_ph), .ev_rx_done(ev_rx),
    .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
    .done(done), .status(status), .rsp_start(rsp_start));

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  logic [1:0]  cap_a [32];
  logic [31:0] cap_d [32];
  int cap_n, hcyc, dcyc, rdy_seen;
  logic [1:0] r_st;
  logic r_rsp;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [MAXB*8-1:0] pl, input int len, input int i);
    logic [31:0] w = 32'h0;
    for (int b = 0; b < 4; b++)
      if (i * 4 + b < len) w = w | (32'(pl[(i*4+b)*8 +: 8]) << (8 * b));
    return w;
  endfunction

  function automatic int n_words(input int len);
    return len / 4 + ((len % 4) != 0 ? 1 : 0);
  endfunction

  // tx_kind: 0 none, 1 payload-empty, 2 header-empty; negative delay = cycle after acceptance
  task automatic run_cmd(input logic [23:0] hdr, input int len, input logic [MAXB*8-1:0] pl,
                         input logic lpm, input logic rbuf, input logic [7:0] rlen,
                         input int tx_kind, input int tx_dly, input int rx_dly, input bit hold);
    bit got = 0;
    cap_n = 0; hcyc = -1; dcyc = -1; rdy_seen = 0;
    @(negedge clk);
    cmd_header = hdr; cmd_pl_len = LENW'(len); cmd_pl_bytes = pl;
    cmd_lpm = lpm; cmd_rx_buf = rbuf; cmd_rx_len = rlen; cmd_valid = 1'b1;
    @(negedge clk);
    if (!hold) cmd_valid = 1'b0;
    for (int k = 1; k < 400 && !got; k++) begin
      ev_pl = 1'b0; ev_ph = 1'b0; ev_rx = 1'b0;
      if (cmd_ready) rdy_seen++;
      if (wr_en && cap_n < 32) begin
        cap_a[cap_n] = wr_addr; cap_d[cap_n] = wr_data; cap_n++;
        if (wr_addr == 2'd2) hcyc = k;
      end
      if (done) begin
        got = 1; dcyc = k; r_st = status; r_rsp = rsp_start; cmd_valid = 1'b0;
      end else begin
        if ((tx_dly < 0 && k == -tx_dly) || (tx_dly >= 0 && hcyc >= 0 && k - hcyc == tx_dly)) begin
          if (tx_kind == 1) ev_pl = 1'b1;
          if (tx_kind == 2) ev_ph = 1'b1;
        end
        if (rx_dly != NONE && ((rx_dly < 0 && k == -rx_dly) ||
            (rx_dly >= 0 && hcyc >= 0 && k - hcyc == rx_dly))) ev_rx = 1'b1;
        @(negedge clk);
      end
    end
    if (!got) chk("R7", "done never seen", 32'd0, 32'd1);
  endtask

  task automatic check_writes(input string req, input logic [23:0] hdr, input int len,
                              input logic [MAXB*8-1:0] pl, input logic lpm);
    int nw = n_words(len);
    chk(req, "write count", 32'(cap_n), 32'(nw + 2));
    if (cap_n == nw + 2) begin
      for (int i = 0; i < nw; i++) begin
        chk("R2", "payload address", 32'(cap_a[i]), 32'd1);
        chk("R3", "payload word", cap_d[i], exp_word(pl, len, i));
      end
      chk("R4", "escape address", 32'(cap_a[nw]), 32'd0);
      chk("R4", "escape word", cap_d[nw], (32'(lpm) << 7) | 32'h0001_0000);
      chk("R5", "header address", 32'(cap_a[nw+1]), 32'd2);
      chk("R5", "header word", cap_d[nw+1],
          32'(hdr[7:0]) | (32'(hdr[15:8]) << 8) | (32'(hdr[23:16]) << 16));
    end
  endtask

  task automatic expect_end(input string req, input int st, input int lat, input logic rsp);
    chk(req, "status", 32'(r_st), 32'(st));
    chk(req, "done latency after header", 32'(dcyc - hcyc), 32'(lat));
    chk("R8", "response hand-over", 32'(r_rsp), 32'(rsp));
  endtask

  function automatic logic [MAXB*8-1:0] rnd_bytes();
    logic [MAXB*8-1:0] v = '0;
    for (int i = 0; i < MAXB; i++) v[i*8 +: 8] = 8'($urandom_range(0, 255));
    return v;
  endfunction

  initial begin
    logic [MAXB*8-1:0] pl;
    logic [23:0] hdr;
    void'($urandom(32'd777));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", 32'(cmd_ready), 32'd1);
    chk("R1", "write strobe after reset", 32'(wr_en), 32'd0);
    chk("R1", "done after reset", 32'(done), 32'd0);
    chk("R1", "rsp_start after reset", 32'(rsp_start), 32'd0);

    // short packet, low power, header-empty event 3 cycles after header
    hdr = {8'h00, 8'h01, {2'd2, 6'h05}};
    run_cmd(hdr, 0, '0, 1'b1, 1'b0, 8'd0, 2, 3, NONE, 0);
    check_writes("R2", hdr, 0, '0, 1'b1);
    expect_end("R6", 0, 4, 1'b0);

    // long packet with trailing group, high speed
    pl = rnd_bytes(); hdr = {8'h00, 8'h05, {2'd1, 6'h39}};
    run_cmd(hdr, 5, pl, 1'b0, 1'b0, 8'd0, 1, 2, NONE, 0);
    check_writes("R3", hdr, 5, pl, 1'b0);
    expect_end("R6", 0, 3, 1'b0);

    // exact multiple of four, and full buffer
    pl = rnd_bytes();
    run_cmd({8'h00, 8'h04, 8'h29}, 4, pl, 1'b1, 1'b0, 8'd0, 1, 1, NONE, 0);
    check_writes("R3", {8'h00, 8'h04, 8'h29}, 4, pl, 1'b1);
    pl = rnd_bytes();
    run_cmd({8'h00, 8'h10, 8'h39}, MAXB, pl, 1'b0, 1'b0, 8'd0, 1, 1, NONE, 0);
    check_writes("R3", {8'h00, 8'h10, 8'h39}, MAXB, pl, 1'b0);

    // wrong-kind events are ignored, wait expires
    run_cmd({8'h00, 8'h00, 8'h05}, 0, '0, 1'b0, 1'b0, 8'd0, 1, 2, NONE, 0);
    expect_end("R6", 1, TMO + 1, 1'b0);
    pl = rnd_bytes();
    run_cmd({8'h00, 8'h03, 8'h39}, 3, pl, 1'b0, 1'b0, 8'd0, 2, 2, NONE, 0);
    expect_end("R7", 1, TMO + 1, 1'b0);

    // argument errors
    run_cmd({8'h00, 8'h00, 8'h06}, 0, '0, 1'b0, 1'b1, 8'd0, 0, NONE, NONE, 0);
    chk("R9", "status buffer without length", 32'(r_st), 32'd2);
    chk("R9", "latency from acceptance", 32'(dcyc), 32'd1);
    chk("R9", "no writes", 32'(cap_n), 32'd0);
    run_cmd({8'h00, 8'h00, 8'h06}, 0, '0, 1'b0, 1'b0, 8'd3, 0, NONE, NONE, 0);
    chk("R9", "status length without buffer", 32'(r_st), 32'd2);
    chk("R9", "no writes", 32'(cap_n), 32'd0);
    run_cmd({8'h00, 8'h11, 8'h39}, MAXB + 1, rnd_bytes(), 1'b0, 1'b0, 8'd0, 0, NONE, NONE, 0);
    chk("R9", "status over-length payload", 32'(r_st), 32'd2);
    chk("R9", "no writes", 32'(cap_n), 32'd0);

    // response expected
    run_cmd({8'h00, 8'h00, 8'h14}, 0, '0, 1'b1, 1'b1, 8'd2, 2, 2, 5, 0);
    expect_end("R8", 0, 6, 1'b1);
    run_cmd({8'h00, 8'h00, 8'h14}, 0, '0, 1'b1, 1'b1, 8'd2, 2, 3, -1, 0);
    expect_end("R8", 0, 5, 1'b1);
    run_cmd({8'h00, 8'h00, 8'h14}, 0, '0, 1'b1, 1'b1, 8'd1, 2, 2, NONE, 0);
    expect_end("R8", 1, 2 + TMO + 1, 1'b0);

    // events while idle are dropped
    @(negedge clk); ev_pl = 1'b1; ev_ph = 1'b1; ev_rx = 1'b1;
    @(negedge clk); ev_pl = 1'b0; ev_ph = 1'b0; ev_rx = 1'b0;
    run_cmd({8'h00, 8'h00, 8'h05}, 0, '0, 1'b0, 1'b0, 8'd0, 0, NONE, NONE, 0);
    expect_end("R10", 1, TMO + 1, 1'b0);

    // early events are remembered
    pl = rnd_bytes();
    run_cmd({8'h00, 8'h09, 8'h39}, 9, pl, 1'b0, 1'b0, 8'd0, 1, -1, NONE, 0);
    expect_end("R10", 0, 2, 1'b0);
    run_cmd({8'h00, 8'h00, 8'h05}, 0, '0, 1'b0, 1'b0, 8'd0, 2, 0, NONE, 0);
    expect_end("R10", 0, 2, 1'b0);

    // valid held during a running command
    run_cmd({8'h00, 8'h00, 8'h15}, 0, '0, 1'b0, 1'b0, 8'd0, 2, 2, NONE, 1);
    chk("R1", "ready seen while busy", 32'(rdy_seen), 32'd0);
    chk("R1", "single command written", 32'(cap_n), 32'd2);
    @(negedge clk);
    chk("R10", "done one cycle", 32'(done), 32'd0);
    chk("R1", "ready back after done", 32'(cmd_ready), 32'd1);
    chk("R1", "no write after done", 32'(wr_en), 32'd0);

    // random commands
    for (int n = 0; n < 30; n++) begin
      int len = $urandom_range(0, MAXB);
      int d = $urandom_range(1, 6);
      logic lpm = 1'($urandom_range(0, 1));
      logic rb = 1'($urandom_range(0, 1));
      int r = rb ? d + $urandom_range(1, 5) : NONE;
      pl = rnd_bytes();
      hdr = 24'($urandom);
      run_cmd(hdr, len, pl, lpm, rb, rb ? 8'($urandom_range(1, 8)) : 8'd0,
              (len != 0) ? 1 : 2, d, r, 0);
      check_writes("R2", hdr, len, pl, lpm);
      expect_end(rb ? "R8" : "R7", 0, rb ? r + 1 : d + 1, rb);
    end

    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule